// File: doc/BRIEF.md
# PWM Configuration Register Bank with AXI4-Lite Slave

This block is the software-facing front of a multi-channel pulse-width generator. It is an AXI4-Lite slave with 16-bit byte addresses and 32-bit data. It holds the per-channel period, width and phase-offset values, three mode flags for the timing engine, a scratch word and a core-hold bit. It also returns fixed identification words. The counters that make the pulses sit outside this block. They read the configuration through flat buses. They take a one-cycle `load_cfg_o` strobe as the cue to adopt new values.

After a system reset the core-hold bit starts in the state given by a build-time parameter. When that parameter enables software bring-up, the block forces all channel outputs low until software clears the hold bit. The load command and the hold bit share one control word. A single write can therefore release the core and request a load together.

Top module: `pwm_cfg_axil`

## Requirements
- R1: Read-only words return fixed values: byte offset 0x00 returns 0x00020101, offset 0x04 returns the `INST_ID` parameter, offset 0x0C returns 0x504C5347, and offset 0x14 returns the channel count `NCH`. Writes to these four offsets change nothing that can be read.
- R2: Offset 0x08 is a read/write scratch word that reads 0 after reset.
- R3: Bit 0 of the control word at offset 0x10 is the core-hold bit. It is read/write, its reset value is the `SW_BRINGUP` parameter, and `core_rst_o` shows its value from the cycle after the write handshake.
- R4: Writing 1 to bit 1 of offset 0x10 drives `load_cfg_o` high for exactly the one cycle after the write handshake. Bit 1 always reads back as 0.
- R5: The mode word at offset 0x18 holds start-at-sync in bit 0 (reset value 1), force-align in bit 1 (reset 0) and ext-sync-align in bit 2 (reset 0). These bits drive `start_at_sync_o`, `force_align_o` and `sync_align_o`.
- R6: For channel n below `NCH`, the period sits at 0x40+4n, the width at 0x80+4n and the offset at 0xC0+4n. Each resets to 0, reads back what was written and appears on bits [32n+31:32n] of `cfg_period_o`, `cfg_width_o` and `cfg_offset_o`.
- R7: Write strobes act per byte: `s_wstrb[k]` enables data bits [8k+7:8k]. The one-bit control and mode fields take effect only when `s_wstrb[0]` is set.
- R8: Reads of unmapped offsets, of offsets that are not multiples of 4, or of channel registers for n ≥ `NCH` return 0 with an OKAY response. Writes to them change nothing.
- R9: The write address and write data are accepted together: `s_awready` and `s_wready` are high only while both valids are high and no response is pending. `s_bvalid` rises in the next cycle with OKAY and holds until `s_bready`.
- R10: `s_arready` is high whenever no read data is pending. `s_rvalid` rises in the next cycle with OKAY, and `s_rdata` stays stable until `s_rready` is high.
- R11: `pwm_o` equals `pwm_i` while the core-hold bit is 0 and is all zeros while it is 1.
- R12: When a read and a write to the same offset are accepted in the same cycle, the read returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low system reset |
| s_awaddr | input | 16 | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | 16 | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| pwm_i | input | NCH | Raw channel waveforms from the timing engine |
| pwm_o | output | NCH | Channel waveforms gated by the core-hold bit |
| cfg_period_o | output | 32*NCH | Staged periods, channel n at bits [32n+31:32n] |
| cfg_width_o | output | 32*NCH | Staged widths |
| cfg_offset_o | output | 32*NCH | Staged phase offsets |
| load_cfg_o | output | 1 | One-cycle load strobe |
| core_rst_o | output | 1 | Held core reset from software |
| start_at_sync_o | output | 1 | Start-at-sync mode flag |
| force_align_o | output | 1 | Force-align mode flag |
| sync_align_o | output | 1 | Ext-sync-align mode flag |

## Verification
Two operations can fall in the same clock edge: a read being captured and a write being committed. This matters most when both target the scratch word. The bench starts both transfers at the same falling edge to the same offset, so both handshakes complete on one rising edge. The read must return the value from before the write, and a second read must return the new value. The load strobe and the core-hold release also happen together when one write sets both control bits. That case is judged by checking `load_cfg_o` and the `pwm_o` gating on the cycle after the handshake and on the cycle after that.

// File: rtl/pwm_cfg_pkg.sv
package pwm_cfg_pkg;

    localparam int unsigned DW     = 32;
    localparam int unsigned AW     = 16;
    localparam int unsigned SW     = DW / 8;
    localparam int unsigned MAX_CH = 16;

    localparam logic [DW-1:0] VERSION_VAL = 32'h0002_0101;
    localparam logic [DW-1:0] MAGIC_VAL   = 32'h504C_5347;

    typedef enum logic [1:0] {
        BANK_MISC   = 2'd0,
        BANK_PERIOD = 2'd1,
        BANK_WIDTH  = 2'd2,
        BANK_OFFSET = 2'd3
    } bank_e;

    localparam logic [3:0] IDX_VERSION = 4'd0;
    localparam logic [3:0] IDX_INST    = 4'd1;
    localparam logic [3:0] IDX_SCRATCH = 4'd2;
    localparam logic [3:0] IDX_MAGIC   = 4'd3;
    localparam logic [3:0] IDX_CTRL    = 4'd4;
    localparam logic [3:0] IDX_COUNT   = 4'd5;
    localparam logic [3:0] IDX_MODE    = 4'd6;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    function automatic logic addr_mapped(input logic [AW-1:0] a);
        return (a[15:8] == 8'h00) && (a[1:0] == 2'b00);
    endfunction

    function automatic bank_e addr_bank(input logic [AW-1:0] a);
        return bank_e'(a[7:6]);
    endfunction

    function automatic logic [3:0] addr_index(input logic [AW-1:0] a);
        return a[5:2];
    endfunction

    function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] old_v,
                                                  input logic [DW-1:0] new_v,
                                                  input logic [SW-1:0] strb);
        logic [DW-1:0] r;
        r = old_v;
        for (int b = 0; b < SW; b++) begin
            if (strb[b]) r[8*b +: 8] = new_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/pwm_axil_wr.sv
module pwm_axil_wr
    import pwm_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] awaddr,
    input  logic          awvalid,
    output logic          awready,
    input  logic [DW-1:0] wdata,
    input  logic [SW-1:0] wstrb,
    input  logic          wvalid,
    output logic          wready,
    output logic [1:0]    bresp,
    output logic          bvalid,
    input  logic          bready,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [SW-1:0] wr_strb
);

    typedef struct packed {
        logic bvalid;
    } wr_st_t;

    wr_st_t d, q;
    logic   accept;

    always_comb begin
        accept = awvalid && wvalid && !q.bvalid;
        d      = q;
        if (accept) begin
            d.bvalid = 1'b1;
        end else if (bready) begin
            d.bvalid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign awready = accept;
    assign wready  = accept;
    assign bvalid  = q.bvalid;
    assign bresp   = RESP_OKAY;
    assign wr_en   = accept;
    assign wr_addr = awaddr;
    assign wr_data = wdata;
    assign wr_strb = wstrb;

    // R9
    bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);

    // R9
    bresp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && awready && wvalid && wready) |=> bvalid);

endmodule

// File: rtl/pwm_axil_rd.sv
module pwm_axil_rd
    import pwm_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] araddr,
    input  logic          arvalid,
    output logic          arready,
    output logic [DW-1:0] rdata,
    output logic [1:0]    rresp,
    output logic          rvalid,
    input  logic          rready,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data
);

    typedef struct packed {
        logic          rvalid;
        logic [DW-1:0] rdata;
    } rd_st_t;

    rd_st_t d, q;
    logic   accept;

    always_comb begin
        accept = arvalid && !q.rvalid;
        d      = q;
        if (accept) begin
            d.rvalid = 1'b1;
            d.rdata  = rd_data;
        end else if (rready) begin
            d.rvalid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign arready = !q.rvalid;
    assign rvalid  = q.rvalid;
    assign rdata   = q.rdata;
    assign rresp   = RESP_OKAY;
    assign rd_addr = araddr;

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

    // R10
    rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && arready) |=> rvalid);

endmodule

// File: rtl/pwm_cfg_store.sv
module pwm_cfg_store
    import pwm_cfg_pkg::*;
#(
    parameter int unsigned NCH        = 4,
    parameter logic [31:0] INST_ID    = 32'h0,
    parameter bit          SW_BRINGUP = 1'b1,
    parameter bit          DEF_SAS    = 1'b1,
    parameter bit          DEF_FA     = 1'b0,
    parameter bit          DEF_ESA    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [SW-1:0]     wr_strb,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic [NCH*DW-1:0] period_o,
    output logic [NCH*DW-1:0] width_o,
    output logic [NCH*DW-1:0] offset_o,
    output logic              load_o,
    output logic              hold_o,
    output logic [2:0]        mode_o
);

    localparam int unsigned MODE_W = 3;

    typedef struct packed {
        logic [DW-1:0]            scratch;
        logic                     hold;
        logic                     load;
        logic [MODE_W-1:0]        mode;
        logic [NCH-1:0][DW-1:0]   period;
        logic [NCH-1:0][DW-1:0]   width;
        logic [NCH-1:0][DW-1:0]   offset;
    } st_t;

    localparam st_t RST_VAL = '{
        scratch: '0,
        hold:    SW_BRINGUP,
        load:    1'b0,
        mode:    {DEF_ESA, DEF_FA, DEF_SAS},
        period:  '0,
        width:   '0,
        offset:  '0
    };

    st_t        d, q;
    bank_e      wr_bank, rd_bank;
    logic [3:0] wr_idx, rd_idx;

    assign wr_bank = addr_bank(wr_addr);
    assign wr_idx  = addr_index(wr_addr);
    assign rd_bank = addr_bank(rd_addr);
    assign rd_idx  = addr_index(rd_addr);

    always_comb begin
        d      = q;
        d.load = 1'b0;
        if (wr_en && addr_mapped(wr_addr)) begin
            unique case (wr_bank)
                BANK_MISC: begin
                    case (wr_idx)
                        IDX_SCRATCH: d.scratch = merge_bytes(q.scratch, wr_data, wr_strb);
                        IDX_CTRL: begin
                            if (wr_strb[0]) begin
                                d.hold = wr_data[0];
                                d.load = wr_data[1];
                            end
                        end
                        IDX_MODE: begin
                            if (wr_strb[0]) d.mode = wr_data[MODE_W-1:0];
                        end
                        default: ;
                    endcase
                end
                BANK_PERIOD: begin
                    for (int n = 0; n < NCH; n++) begin
                        if (wr_idx == 4'(n))
                            d.period[n] = merge_bytes(q.period[n], wr_data, wr_strb);
                    end
                end
                BANK_WIDTH: begin
                    for (int n = 0; n < NCH; n++) begin
                        if (wr_idx == 4'(n))
                            d.width[n] = merge_bytes(q.width[n], wr_data, wr_strb);
                    end
                end
                BANK_OFFSET: begin
                    for (int n = 0; n < NCH; n++) begin
                        if (wr_idx == 4'(n))
                            d.offset[n] = merge_bytes(q.offset[n], wr_data, wr_strb);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    always_comb begin
        rd_data = '0;
        if (addr_mapped(rd_addr)) begin
            unique case (rd_bank)
                BANK_MISC: begin
                    case (rd_idx)
                        IDX_VERSION: rd_data = VERSION_VAL;
                        IDX_INST:    rd_data = INST_ID;
                        IDX_SCRATCH: rd_data = q.scratch;
                        IDX_MAGIC:   rd_data = MAGIC_VAL;
                        IDX_CTRL:    rd_data = {{(DW-1){1'b0}}, q.hold};
                        IDX_COUNT:   rd_data = DW'(NCH);
                        IDX_MODE:    rd_data = {{(DW-MODE_W){1'b0}}, q.mode};
                        default:     rd_data = '0;
                    endcase
                end
                BANK_PERIOD: begin
                    for (int n = 0; n < NCH; n++) begin
                        if (rd_idx == 4'(n)) rd_data = q.period[n];
                    end
                end
                BANK_WIDTH: begin
                    for (int n = 0; n < NCH; n++) begin
                        if (rd_idx == 4'(n)) rd_data = q.width[n];
                    end
                end
                BANK_OFFSET: begin
                    for (int n = 0; n < NCH; n++) begin
                        if (rd_idx == 4'(n)) rd_data = q.offset[n];
                    end
                end
                default: rd_data = '0;
            endcase
        end
    end

    assign period_o = q.period;
    assign width_o  = q.width;
    assign offset_o = q.offset;
    assign load_o   = q.load;
    assign hold_o   = q.hold;
    assign mode_o   = q.mode;

    // R4
    load_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);

    // R3
    hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 16'h0010 && wr_strb[0]) |=> (hold_o == $past(wr_data[0])));

    // R8
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:8] != 8'h00) |=> ($stable(period_o) && $stable(width_o)
                                               && $stable(offset_o) && !load_o));

endmodule

// File: rtl/pwm_out_gate.sv
module pwm_out_gate #(
    parameter int unsigned NCH = 4
) (
    input  logic           hold,
    input  logic [NCH-1:0] pwm_i,
    output logic [NCH-1:0] pwm_o
);

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        assign pwm_o[n] = pwm_i[n] & ~hold;
    end

endmodule

// File: rtl/pwm_cfg_axil.sv
module pwm_cfg_axil
    import pwm_cfg_pkg::*;
#(
    parameter int unsigned NCH        = 4,
    parameter logic [31:0] INST_ID    = 32'h0,
    parameter bit          SW_BRINGUP = 1'b1,
    parameter bit          DEF_SAS    = 1'b1,
    parameter bit          DEF_FA     = 1'b0,
    parameter bit          DEF_ESA    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [15:0]       s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  logic [NCH-1:0]    pwm_i,
    output logic [NCH-1:0]    pwm_o,
    output logic [NCH*32-1:0] cfg_period_o,
    output logic [NCH*32-1:0] cfg_width_o,
    output logic [NCH*32-1:0] cfg_offset_o,
    output logic              load_cfg_o,
    output logic              core_rst_o,
    output logic              start_at_sync_o,
    output logic              force_align_o,
    output logic              sync_align_o
);

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [SW-1:0] wr_strb;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic [2:0]    mode;

    pwm_axil_wr u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .awaddr  (s_awaddr),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .wdata   (s_wdata),
        .wstrb   (s_wstrb),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .bresp   (s_bresp),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_strb (wr_strb)
    );

    pwm_axil_rd u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .araddr  (s_araddr),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .rdata   (s_rdata),
        .rresp   (s_rresp),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    pwm_cfg_store #(
        .NCH        (NCH),
        .INST_ID    (INST_ID),
        .SW_BRINGUP (SW_BRINGUP),
        .DEF_SAS    (DEF_SAS),
        .DEF_FA     (DEF_FA),
        .DEF_ESA    (DEF_ESA)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_strb  (wr_strb),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .period_o (cfg_period_o),
        .width_o  (cfg_width_o),
        .offset_o (cfg_offset_o),
        .load_o   (load_cfg_o),
        .hold_o   (core_rst_o),
        .mode_o   (mode)
    );

    pwm_out_gate #(.NCH(NCH)) u_gate (
        .hold  (core_rst_o),
        .pwm_i (pwm_i),
        .pwm_o (pwm_o)
    );

    assign start_at_sync_o = mode[0];
    assign force_align_o   = mode[1];
    assign sync_align_o    = mode[2];

    // R11
    gated_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |-> (pwm_o == '0));

endmodule

// File: tb/pwm_cfg_axil_tb.sv
module pwm_cfg_axil_tb;

    localparam int          NCH     = 4;
    localparam logic [31:0] INST_ID = 32'h0000_00A5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       s_awaddr = '0;
    logic              s_awvalid = 1'b0;
    logic              s_awready;
    logic [31:0]       s_wdata = '0;
    logic [3:0]        s_wstrb = '0;
    logic              s_wvalid = 1'b0;
    logic              s_wready;
    logic [1:0]        s_bresp;
    logic              s_bvalid;
    logic              s_bready = 1'b1;
    logic [15:0]       s_araddr = '0;
    logic              s_arvalid = 1'b0;
    logic              s_arready;
    logic [31:0]       s_rdata;
    logic [1:0]        s_rresp;
    logic              s_rvalid;
    logic              s_rready = 1'b1;
    logic [NCH-1:0]    pwm_i = '1;
    logic [NCH-1:0]    pwm_o;
    logic [NCH*32-1:0] cfg_period_o, cfg_width_o, cfg_offset_o;
    logic              load_cfg_o, core_rst_o;
    logic              start_at_sync_o, force_align_o, sync_align_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    pwm_cfg_axil #(.NCH(NCH), .INST_ID(INST_ID)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .pwm_i(pwm_i), .pwm_o(pwm_o),
        .cfg_period_o(cfg_period_o), .cfg_width_o(cfg_width_o), .cfg_offset_o(cfg_offset_o),
        .load_cfg_o(load_cfg_o), .core_rst_o(core_rst_o),
        .start_at_sync_o(start_at_sync_o), .force_align_o(force_align_o),
        .sync_align_o(sync_align_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: scoreboard for read beats
    always @(negedge clk) begin
        if (rst_n && s_rvalid && s_rready) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R10: actual 0x%08h expected no beat", s_rdata);
            end else begin
                chk(tag_q.pop_front(), s_rdata, exp_q.pop_front());
                chk("R10 rresp", {30'b0, s_rresp}, 32'h0);
            end
        end
    end

    task automatic axi_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        s_awaddr = a; s_wdata = d; s_wstrb = s;
        s_awvalid = 1'b1; s_wvalid = 1'b1;
        #1;
        while (!s_awready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
    endtask

    task automatic axi_read(input logic [15:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1'b1;
        #1;
        while (!s_arready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R3 core_rst reset", {31'b0, core_rst_o}, 32'h1);
        chk("R11 gated at reset", {28'b0, pwm_o}, 32'h0);
        chk("R4 load idle", {31'b0, load_cfg_o}, 32'h0);
        chk("R5 mode outs reset", {29'b0, sync_align_o, force_align_o, start_at_sync_o}, 32'h1);
        chk("R9 bvalid reset", {31'b0, s_bvalid}, 32'h0);
        chk("R10 rvalid reset", {31'b0, s_rvalid}, 32'h0);
        axi_read(16'h0000, 32'h0002_0101, "R1 version");
        axi_read(16'h0004, INST_ID, "R1 inst id");
        axi_read(16'h0008, 32'h0, "R2 scratch reset");
        axi_read(16'h000C, 32'h504C_5347, "R1 magic");
        axi_read(16'h0010, 32'h1, "R3 ctrl reset");
        axi_read(16'h0014, NCH, "R1 count");
        axi_read(16'h0018, 32'h1, "R5 mode reset");
        axi_read(16'h0040, 32'h0, "R6 period0 reset");

        // read-only words ignore writes
        axi_write(16'h0000, 32'hFFFF_FFFF, 4'hF);
        axi_write(16'h000C, 32'h0, 4'hF);
        axi_write(16'h0014, 32'h0, 4'hF);
        axi_read(16'h0000, 32'h0002_0101, "R1 version after write");
        axi_read(16'h000C, 32'h504C_5347, "R1 magic after write");
        axi_read(16'h0014, NCH, "R1 count after write");

        // scratch and byte strobes
        axi_write(16'h0008, 32'h1234_5678, 4'hF);
        axi_read(16'h0008, 32'h1234_5678, "R2 scratch");
        axi_write(16'h0008, 32'hAABB_CCDD, 4'b0101);
        axi_read(16'h0008, 32'h12BB_56DD, "R7 scratch strobes");

        // per-channel registers
        axi_write(16'h0048, 32'h0000_0100, 4'hF);
        axi_write(16'h008C, 32'h0000_0055, 4'hF);
        axi_write(16'h00C4, 32'hFFFF_FF77, 4'b0001);
        axi_read(16'h0048, 32'h0000_0100, "R6 period2");
        axi_read(16'h008C, 32'h0000_0055, "R6 width3");
        axi_read(16'h00C4, 32'h0000_0077, "R7 offset1 lane0");
        chk("R6 period2 bus", cfg_period_o[2*32 +: 32], 32'h0000_0100);
        chk("R6 width3 bus", cfg_width_o[3*32 +: 32], 32'h0000_0055);
        chk("R6 offset1 bus", cfg_offset_o[1*32 +: 32], 32'h0000_0077);
        chk("R6 period0 bus", cfg_period_o[0 +: 32], 32'h0);

        // unmapped and out-of-range channels
        axi_write(16'h0054, 32'h0000_0099, 4'hF);
        axi_write(16'h0149, 32'h0000_0042, 4'hF);
        axi_read(16'h0054, 32'h0, "R8 channel5 period");
        axi_read(16'h001C, 32'h0, "R8 gap word");
        axi_read(16'h0100, 32'h0, "R8 high offset");
        axi_read(16'h0049, 32'h0, "R8 misaligned");
        axi_read(16'h0048, 32'h0000_0100, "R8 period2 unchanged");

        // mode flags
        axi_write(16'h0018, 32'h0000_0006, 4'hF);
        axi_read(16'h0018, 32'h6, "R5 mode write");
        chk("R5 mode outs", {29'b0, sync_align_o, force_align_o, start_at_sync_o}, 32'h6);
        axi_write(16'h0018, 32'h0000_0001, 4'b1110);
        axi_read(16'h0018, 32'h6, "R7 mode lane0 off");

        // control: release hold plus load
        axi_write(16'h0010, 32'h0000_0002, 4'h1);
        chk("R4 load pulse", {31'b0, load_cfg_o}, 32'h1);
        chk("R3 hold released", {31'b0, core_rst_o}, 32'h0);
        chk("R11 pwm passes", {28'b0, pwm_o}, 32'hF);
        @(negedge clk);
        chk("R4 load one cycle", {31'b0, load_cfg_o}, 32'h0);
        pwm_i = 4'b1010;
        #1;
        chk("R11 pwm follows", {28'b0, pwm_o}, 32'hA);
        axi_read(16'h0010, 32'h0, "R4 load reads zero");
        axi_write(16'h0010, 32'h0000_0001, 4'h1);
        chk("R3 hold set", {31'b0, core_rst_o}, 32'h1);
        chk("R4 no load", {31'b0, load_cfg_o}, 32'h0);
        chk("R11 pwm gated", {28'b0, pwm_o}, 32'h0);
        axi_write(16'h0010, 32'h0000_0002, 4'hE);
        chk("R7 ctrl lane0 off load", {31'b0, load_cfg_o}, 32'h0);
        chk("R7 ctrl lane0 off hold", {31'b0, core_rst_o}, 32'h1);

        // write handshake: address alone is not taken
        @(negedge clk);
        s_awaddr = 16'h0008; s_awvalid = 1'b1; s_wvalid = 1'b0;
        #1;
        chk("R9 awready waits wvalid", {30'b0, s_awready, s_wready}, 32'h0);
        @(negedge clk);
        chk("R9 awready still low", {31'b0, s_awready}, 32'h0);
        s_awvalid = 1'b0;
        s_bready = 1'b0;
        axi_write(16'h0008, 32'hCAFE_F00D, 4'hF);
        chk("R9 bvalid up", {31'b0, s_bvalid}, 32'h1);
        chk("R9 bresp okay", {30'b0, s_bresp}, 32'h0);
        @(negedge clk);
        chk("R9 bvalid held", {31'b0, s_bvalid}, 32'h1);
        s_bready = 1'b1;
        @(negedge clk);
        chk("R9 bvalid drop", {31'b0, s_bvalid}, 32'h0);

        // read stall
        s_rready = 1'b0;
        axi_read(16'h000C, 32'h504C_5347, "R10 stalled beat");
        chk("R10 rvalid up", {31'b0, s_rvalid}, 32'h1);
        chk("R10 arready low", {31'b0, s_arready}, 32'h0);
        @(negedge clk);
        chk("R10 rvalid held", {31'b0, s_rvalid}, 32'h1);
        chk("R10 rdata held", s_rdata, 32'h504C_5347);
        @(posedge clk);
        #1 s_rready = 1'b1;
        @(negedge clk);
        @(negedge clk);

        // collision: read and write same word on same edge
        fork
            axi_write(16'h0008, 32'h0BAD_BEEF, 4'hF);
            axi_read(16'h0008, 32'hCAFE_F00D, "R12 read sees old value");
        join
        axi_read(16'h0008, 32'h0BAD_BEEF, "R12 later read sees new value");
        repeat (3) @(negedge clk);
        chk("R10 scoreboard drained", exp_q.size(), 32'h0);
        finish_run();
    end

endmodule